// File: doc/BRIEF.md
# Dual-Mode Serial Port

A byte-wide serial peripheral that either frames characters as an asynchronous UART or exchanges bytes over a clock-synchronous shift link. Software reaches it through a four-address bus. One address is shared: writing it loads a one-byte transmit holding buffer and reading it returns a one-byte receive buffer. The other addresses hold status, control and the reload value of a built-in baud-rate generator. The holding buffer feeds a transmit shift register, and a receive shift register fills the receive buffer, so one byte can wait on each side while another is on the wire.

The baud-rate generator is an 8-bit reload down-counter. Its count source is the system clock or the system clock divided by 4, and its output flips on every underflow. In UART mode each bit spans 16 shift-clock ticks. In synchronous mode, with the internal clock, each bit spans 4 ticks and the port drives its own shift clock. The shift clock comes either from the generator or from an external clock input (rising edges are counted). In synchronous mode with the external clock, the output bit changes on a falling edge and the input is sampled on a rising edge. A synchronous transfer is a full-duplex exchange: every transmitted byte also clocks one byte in.

Status flags report the buffer and shift states and the receive errors. Errors also show as a combined flag. Two level interrupts are provided. The transmit interrupt follows either buffer-empty or shift-completed, as software selects. A ready output tells a synchronous partner that the receive buffer can take a byte.

Top module: `dual_serial_port`

## Requirements
- R1: After reset the status register (address 1) reads 0x81 and the control register reads 0x00. Status bit 7 always reads 1, and writes to address 1 change no status bit. Status bits: 0 transmit buffer empty, 1 receive buffer full, 2 shift completed, 3 overrun, 4 parity error, 5 framing error, 6 OR of bits 3 to 5.
- R2: While control bit 7 (unit enable) is 0 nothing is shifted: txd stays 1, and a byte written to address 0 stays pending (status bit 0 stays 0). It is sent once the unit is enabled.
- R3: Control bit 0 picks the generator source: 0 = system clock, 1 = system clock / 4. With reload value N (address 3), the generator output completes one period every 2(N+1) source ticks. A UART bit therefore lasts 16·2(N+1) clocks (×4 when bit 0 is 1).
- R4: In UART mode with control bit 1 set, each bit lasts 16 rising edges of ext_clk.
- R5: A UART frame is a low start bit, 8 data bits LSB first, an even parity bit (the XOR of the data) and a high stop bit. txd idles high.
- R6: Writing address 0 clears status bit 0. When the shift register is idle, the pending byte moves into it on the next shift tick, which sets bit 0 again and clears bit 2. Bit 2 sets after the last bit when no byte is pending.
- R7: tx_irq is high when the unit and transmitter are enabled and the selected flag is set: control bit 3 = 0 selects buffer empty (status bit 0), 1 selects shift completed (status bit 2).
- R8: The UART receiver samples each bit at mid-bit. A good frame is placed in the receive buffer and sets status bit 1. Reading address 0 returns the byte and clears bit 1. rx_irq follows bit 1 while receive (control bit 5) and unit are enabled.
- R9: A parity mismatch sets status bit 4. A stop bit sampled low sets bit 5. Either one sets bit 6.
- R10: A byte that completes while status bit 1 is still set raises bit 3 and is discarded; the buffer keeps the earlier byte.
- R11: The error bits clear only when address 1 is read and then address 0 is read. Reading address 0 with no status read since the last clear leaves them set.
- R12: In synchronous mode (control bit 6 = 1) with the internal clock, sclk_oe is high and sclk_out idles high. Each byte is sent LSB first with txd valid at each sclk_out rising edge, and rxd is captured at those same edges.
- R13: rdy_out is high when control bit 2, the unit, synchronous mode and the receiver are all enabled and the receive buffer is empty. rdy_oe follows control bit 2.
- R14: Address 2 (control) and address 3 (generator reload) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control, 3 generator reload |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (reads of addresses 0 and 1 have side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| ext_clk | input | 1 | External shift clock |
| rxd | input | 1 | Serial data in |
| txd | output | 1 | Serial data out |
| sclk_out | output | 1 | Synchronous shift clock driven by the port |
| sclk_oe | output | 1 | Enable for sclk_out |
| rdy_out | output | 1 | Receive-ready indication |
| rdy_oe | output | 1 | Ready pin drive enable |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
Some rules are checked on every cycle: a buffer write empties nothing, a receive-buffer read drops the full flag, no overrun overwrites the stored byte, an error flag holds until a data read, shift-completed stays clear while shifting, and the ready output drops as a byte lands. Other behaviour only the scenarios can show. Frame layout and parity, bit duration for each clock source and divider, and mid-bit sampling are checked by decoding txd and driving rxd. The status-then-data clearing order, the enable gate and the full-duplex synchronous loopback are also checked there.

// File: rtl/dual_serial_port.sv
`timescale 1ns/1ps
module dual_serial_port #(
  parameter int UART_OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ext_clk,
  input  logic       rxd,
  output logic       txd,
  output logic       sclk_out,
  output logic       sclk_oe,
  output logic       rdy_out,
  output logic       rdy_oe,
  output logic       tx_irq,
  output logic       rx_irq
);
  localparam int SUB_W = $clog2(UART_OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UART_OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(UART_OVS / 2 - 1);

  logic [7:0] ctl, brg_rld, brg_cnt;
  logic       css, scs, rdy_en, tic, te, re, syn, en;
  assign {en, syn, re, te, tic, rdy_en, scs, css} = ctl;

  logic       wr_dat, rd_dat, rd_st;
  assign wr_dat = bus_wr && bus_addr == 2'd0;
  assign rd_dat = bus_rd && bus_addr == 2'd0;
  assign rd_st  = bus_rd && bus_addr == 2'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl <= '0;
      brg_rld <= '0;
    end else if (bus_wr) begin
      if (bus_addr == 2'd2) ctl <= bus_wdata;
      if (bus_addr == 2'd3) brg_rld <= bus_wdata;
    end

  // baud generator and clock selection
  logic [1:0] pre, ph;
  logic       brg_out, src_tick, brg_tick;
  logic [2:0] ext_s;
  logic [1:0] rx_s;
  logic       ext_rise, ext_fall, rxi, u_tick, drv, smp;

  assign src_tick = !css || pre == 2'd3;
  assign brg_tick = src_tick && brg_cnt == '0 && !brg_out;
  assign ext_rise = ext_s[1] && !ext_s[2];
  assign ext_fall = !ext_s[1] && ext_s[2];
  assign rxi      = rx_s[1];
  assign u_tick   = scs ? ext_rise : brg_tick;
  assign drv      = scs ? ext_fall : (brg_tick && ph == 2'd0);
  assign smp      = scs ? ext_rise : (brg_tick && ph == 2'd2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0; ph <= '0; brg_out <= 1'b0; brg_cnt <= '0;
      ext_s <= '0; rx_s <= 2'b11;
    end else begin
      pre   <= pre + 2'd1;
      ext_s <= {ext_s[1:0], ext_clk};
      rx_s  <= {rx_s[0], rxd};
      if (brg_tick) ph <= ph + 2'd1;
      if (src_tick) begin
        if (brg_cnt == '0) begin
          brg_cnt <= brg_rld;
          brg_out <= ~brg_out;
        end else brg_cnt <= brg_cnt - 8'd1;
      end
    end

  // transmitter
  logic [7:0]       txbuf;
  logic [10:0]      txsr;
  logic [3:0]       tx_left;
  logic [SUB_W-1:0] tx_sub;
  logic             tbe, tsc, busy, tx_step, tx_last, tx_load;

  assign tx_step = syn ? drv : u_tick;
  assign tx_last = busy && tx_left == 4'd1 && (syn || tx_sub == SUB_LAST);
  assign tx_load = en && te && !tbe && tx_step && (!busy || tx_last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txbuf <= '0; txsr <= '1; tx_left <= '0; tx_sub <= '0;
      tbe <= 1'b1; tsc <= 1'b0; busy <= 1'b0;
    end else begin
      if (!en) busy <= 1'b0;
      else if (tx_load) begin
        busy    <= 1'b1;
        tsc     <= 1'b0;
        tbe     <= 1'b1;
        txsr    <= syn ? {3'b111, txbuf} : {1'b1, ^txbuf, txbuf, 1'b0};
        tx_left <= syn ? 4'd8 : 4'd11;
        tx_sub  <= '0;
      end else if (tx_step && busy) begin
        if (tx_last) begin
          busy <= 1'b0;
          tsc  <= 1'b1;
        end else if (syn || tx_sub == SUB_LAST) begin
          txsr    <= {1'b1, txsr[10:1]};
          tx_left <= tx_left - 4'd1;
          tx_sub  <= '0;
        end else tx_sub <= tx_sub + 1'b1;
      end
      if (wr_dat) begin
        txbuf <= bus_wdata;
        tbe   <= 1'b0;
      end
    end

  // receiver
  logic [7:0]       rxbuf, rxsr, rx_byte;
  logic [3:0]       rx_bit;
  logic [SUB_W-1:0] rx_sub;
  logic             rx_act, rx_par, rx_done, rbf, oe, pe, fe, st_seen;

  assign rx_done = en && re && (syn ? (smp && busy && rx_bit == 4'd7)
                                    : (u_tick && rx_act && rx_sub == SUB_MID && rx_bit == 4'd10));
  assign rx_byte = syn ? {rxi, rxsr[7:1]} : rxsr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxsr <= '0; rx_bit <= '0; rx_sub <= '0; rx_act <= 1'b0; rx_par <= 1'b0;
    end else if (!en || !re) rx_act <= 1'b0;
    else if (syn) begin
      if (tx_load) rx_bit <= '0;
      else if (smp && busy) begin
        rxsr   <= {rxi, rxsr[7:1]};
        rx_bit <= rx_bit + 4'd1;
      end
    end else if (u_tick) begin
      if (!rx_act) begin
        if (!rxi) begin
          rx_act <= 1'b1; rx_sub <= '0; rx_bit <= '0;
        end
      end else begin
        rx_sub <= rx_sub + 1'b1;
        if (rx_sub == SUB_LAST) rx_bit <= rx_bit + 4'd1;
        if (rx_sub == SUB_MID) begin
          if (rx_bit == 4'd0) begin
            if (rxi) rx_act <= 1'b0;
          end else if (rx_bit <= 4'd8) rxsr <= {rxi, rxsr[7:1]};
          else if (rx_bit == 4'd9) rx_par <= rxi;
          else rx_act <= 1'b0;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxbuf <= '0; rbf <= 1'b0; oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; st_seen <= 1'b0;
    end else begin
      if (rd_st) st_seen <= 1'b1;
      if (rd_dat) begin
        rbf <= 1'b0;
        if (st_seen) begin
          oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; st_seen <= 1'b0;
        end
      end
      if (rx_done) begin
        if (rbf && !rd_dat) oe <= 1'b1;
        else begin
          rxbuf <= rx_byte;
          rbf   <= 1'b1;
          if (!syn && rx_par != ^rxsr) pe <= 1'b1;
          if (!syn && !rxi) fe <= 1'b1;
        end
      end
    end

  assign txd      = busy ? txsr[0] : 1'b1;
  assign sclk_oe  = en && syn && !scs;
  assign sclk_out = !busy || ph[1] == ph[0];
  assign rdy_oe   = rdy_en;
  assign rdy_out  = rdy_en && en && syn && re && !rbf;
  assign tx_irq   = en && te && (tic ? tsc : tbe);
  assign rx_irq   = en && re && rbf;

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = rxbuf;
      2'd1:    bus_rdata = {1'b1, oe | pe | fe, fe, pe, oe, tsc, rbf, tbe};
      2'd2:    bus_rdata = ctl;
      default: bus_rdata = brg_rld;
    endcase
endmodule

// File: rtl/dual_serial_port_chk.sv
`timescale 1ns/1ps
module dual_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       en,
  input logic       tic,
  input logic       txd,
  input logic       tbe,
  input logic       tsc,
  input logic       busy,
  input logic       rbf,
  input logic       oe,
  input logic [7:0] rxbuf,
  input logic       rx_done,
  input logic       rdy_out,
  input logic       tx_irq
);
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> txd);
  p_write_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> !tbe);
  p_no_done_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tsc);
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tic && busy) |-> !tx_irq);
  p_read_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0 && !rx_done) |=> !rbf);
  p_keep_old_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rbf && !(bus_rd && bus_addr == 2'd0)) |=> ($stable(rxbuf) && oe));
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !(bus_rd && bus_addr == 2'd0)) |=> oe);
  p_ready_drops_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rdy_out) |=> !rdy_out);
endmodule

bind dual_serial_port dual_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .en(ctl[7]), .tic(ctl[3]), .txd(txd), .tbe(tbe), .tsc(tsc), .busy(busy),
  .rbf(rbf), .oe(oe), .rxbuf(rxbuf), .rx_done(rx_done), .rdy_out(rdy_out),
  .tx_irq(tx_irq)
);

// File: tb/test_dual_serial_port.sv
`timescale 1ns/1ps
module test_dual_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic ext_clk = 1'b0, rxd_drv = 1'b1, loop = 1'b0, rxd_w;
  logic txd, sclk_out, sclk_oe, rdy_out, rdy_oe, tx_irq, rx_irq;

  int n_chk = 0, n_fail = 0, bit_clks = 32;
  logic mon_uart = 1'b0, mon_sync = 1'b0, ext_run = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] rv;

  always #2.5 clk = ~clk;
  assign rxd_w = loop ? txd : rxd_drv;

  dual_serial_port i_dual_serial_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk), .rxd(rxd_w),
    .txd(txd), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rdy_out(rdy_out),
    .rdy_oe(rdy_oe), .tx_irq(tx_irq), .rx_irq(rx_irq));

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] d);
    exp_tx.push_back(d);
    bus_write(2'd0, d);
  endtask

  task automatic send_uart(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    rxd_drv = 1'b0; wait_clks(bit_clks);
    for (int i = 0; i < 8; i++) begin rxd_drv = d[i]; wait_clks(bit_clks); end
    rxd_drv = ^d ^ bad_par; wait_clks(bit_clks);
    rxd_drv = !bad_stop; wait_clks(bit_clks);
    rxd_drv = 1'b1; wait_clks(bit_clks);
  endtask

  // UART transmit monitor
  logic [9:0] m_frame;
  logic [7:0] m_exp;
  initial forever begin
    @(negedge clk);
    if (mon_uart && txd === 1'b0) begin
      wait_clks(bit_clks / 2);
      m_frame[0] = txd;
      for (int i = 0; i < 8; i++) begin wait_clks(bit_clks); m_frame[i+1] = txd; end
      wait_clks(bit_clks); m_frame[9] = txd;
      wait_clks(bit_clks);
      if (exp_tx.size() == 0) check("R5 unexpected frame", {txd, m_frame[9:1]}, 10'h3FF);
      else begin
        m_exp = exp_tx.pop_front();
        check("R5 start bit", {9'd0, m_frame[0]}, 10'd0);
        check("R5 frame data/parity/stop", {txd, m_frame[9:1]}, {1'b1, ^m_exp, m_exp});
      end
    end
  end

  // synchronous transmit monitor
  logic s_prev = 1'b1;
  logic [7:0] s_bits;
  int s_cnt = 0;
  initial forever begin
    @(negedge clk);
    if (!mon_sync) s_cnt = 0;
    else if (sclk_out && !s_prev) begin
      s_bits[s_cnt] = txd;
      s_cnt++;
      if (s_cnt == 8) begin
        s_cnt = 0;
        if (exp_tx.size() == 0) check("R12 unexpected byte", {2'b0, s_bits}, 10'h3FF);
        else check("R12 sync byte", {2'b0, s_bits}, {2'b0, exp_tx.pop_front()});
      end
    end
    s_prev = sclk_out;
  end

  initial forever begin
    wait_clks(4);
    if (ext_run) ext_clk = ~ext_clk;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);
    bus_read(2'd1, rv); check("R1 status reset", {2'b0, rv}, 10'h081);
    bus_read(2'd2, rv); check("R1 control reset", {2'b0, rv}, 10'h000);
    check("R1 idle line/irq", {8'd0, txd, tx_irq}, 10'b10);
    bus_write(2'd1, 8'h7E);
    bus_read(2'd1, rv); check("R1 status write ignored", {2'b0, rv}, 10'h081);

    bus_write(2'd3, 8'h00);
    bus_read(2'd3, rv); check("R14 reload readback", {2'b0, rv}, 10'h000);
    bus_write(2'd2, 8'hB0);
    bus_read(2'd2, rv); check("R14 control readback", {2'b0, rv}, 10'h0B0);

    // UART transmit, flags
    bit_clks = 32; mon_uart = 1'b1;
    send_tx(8'hA5);
    wait_clks(20);
    bus_read(2'd1, rv); check("R6 loaded: empty, shifting", {7'd0, rv[2:0]}, 10'b001);
    check("R7 irq on empty", {9'd0, tx_irq}, 10'd1);
    wait_clks(11 * 32 + 40);
    bus_read(2'd1, rv); check("R6 shift completed", {7'd0, rv[2:0]}, 10'b101);

    bus_write(2'd2, 8'hB8);
    check("R7 irq on completion", {9'd0, tx_irq}, 10'd1);
    send_tx(8'h3C);
    wait_clks(20);
    check("R7 irq low while shifting", {9'd0, tx_irq}, 10'd0);
    wait_clks(11 * 32 + 40);
    check("R7 irq after completion", {9'd0, tx_irq}, 10'd1);

    // UART receive
    send_uart(8'h96, 1'b0, 1'b0);
    bus_read(2'd1, rv); check("R8 buffer full", {2'b0, rv & 8'hFA}, 10'h082);
    check("R8 rx irq", {9'd0, rx_irq}, 10'd1);
    bus_read(2'd0, rv); check("R8 rx data", {2'b0, rv}, 10'h096);
    bus_read(2'd1, rv); check("R8 full cleared", {2'b0, rv & 8'hFA}, 10'h080);

    bus_read(2'd0, rv);
    send_uart(8'h3C, 1'b1, 1'b0);
    bus_read(2'd1, rv); check("R9 parity error", {2'b0, rv & 8'hFA}, 10'h0D2);
    bus_read(2'd0, rv); check("R9 data kept", {2'b0, rv}, 10'h03C);
    bus_read(2'd1, rv); check("R11 cleared after status+data", {2'b0, rv & 8'hFA}, 10'h080);

    bus_read(2'd0, rv);
    send_uart(8'h5B, 1'b0, 1'b1);
    bus_read(2'd0, rv); check("R9 framing data", {2'b0, rv}, 10'h05B);
    bus_read(2'd1, rv); check("R11 errors persist, R9 framing", {2'b0, rv & 8'hFA}, 10'h0E0);
    bus_read(2'd0, rv);
    bus_read(2'd1, rv); check("R11 framing cleared", {2'b0, rv & 8'hFA}, 10'h080);

    bus_read(2'd0, rv);
    send_uart(8'h11, 1'b0, 1'b0);
    send_uart(8'h22, 1'b0, 1'b0);
    bus_read(2'd1, rv); check("R10 overrun", {2'b0, rv & 8'hFA}, 10'h0CA);
    bus_read(2'd0, rv); check("R10 first byte kept", {2'b0, rv}, 10'h011);
    bus_read(2'd1, rv); check("R10 overrun cleared", {2'b0, rv & 8'hFA}, 10'h080);
    bus_read(2'd0, rv);

    // synchronous loopback
    mon_uart = 1'b0;
    bus_write(2'd2, 8'hF4);
    mon_sync = 1'b1; loop = 1'b1;
    wait_clks(4);
    check("R12 clock driven, idle high", {8'd0, sclk_oe, sclk_out}, 10'b11);
    check("R13 ready with empty buffer", {8'd0, rdy_oe, rdy_out}, 10'b11);
    send_tx(8'h5A);
    wait_clks(120);
    check("R13 ready drops when full", {9'd0, rdy_out}, 10'd0);
    bus_read(2'd1, rv); check("R12 buffer full", {2'b0, rv & 8'hFA}, 10'h082);
    bus_read(2'd0, rv); check("R12 looped byte", {2'b0, rv}, 10'h05A);
    check("R13 ready returns", {9'd0, rdy_out}, 10'd1);
    mon_sync = 1'b0; loop = 1'b0;
    bus_write(2'd2, 8'h00);

    // divided source, reload 2
    bus_write(2'd3, 8'h02);
    bit_clks = 384; mon_uart = 1'b1;
    bus_write(2'd2, 8'hB1);
    send_tx(8'h0F);
    wait_clks(11 * 384 + 500);
    check("R3 divided-source frame consumed", {2'b0, 8'(exp_tx.size())}, 10'd0);

    // external clock
    ext_run = 1'b1; bit_clks = 128;
    bus_write(2'd2, 8'hB2);
    wait_clks(40);
    send_tx(8'hC3);
    wait_clks(11 * 128 + 300);
    check("R4 external-clock frame consumed", {2'b0, 8'(exp_tx.size())}, 10'd0);
    ext_run = 1'b0;

    // unit disabled
    bus_write(2'd3, 8'h00);
    bus_write(2'd2, 8'h30);
    bus_write(2'd0, 8'h44);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) check("R2 line quiet while off", {9'd0, txd}, 10'd1);
    end
    n_chk++;
    bus_read(2'd1, rv); check("R2 byte stays pending", {9'd0, rv[0]}, 10'd0);
    check("R2 no irq while off", {9'd0, tx_irq}, 10'd0);
    bit_clks = 32;
    exp_tx.push_back(8'h44);
    bus_write(2'd2, 8'hB0);
    wait_clks(11 * 32 + 60);
    bus_read(2'd1, rv); check("R2 pending byte sent", {7'd0, rv[2:0]}, 10'b101);
    check("R5 all frames seen", {2'b0, 8'(exp_tx.size())}, 10'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule